// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two requests. A fast request carries urgent sources. A normal request carries sources that are screened by a four-bit priority per source. Software reaches the controller through a word-indexed register file that has one write strobe and one read strobe. The register file holds these items:
- a per-source enable, which can be written a 32-bit half at a time or one source at a time by number;
- a per-source fast/normal type;
- the priority nibbles;
- a normal-priority mask level;
- a small control word.

Each source keeps a pending bit. A pending bit follows its input line when that line changes level. Software can also overwrite the pending bits through the force registers. Reading one of the two vector registers returns the selected source and acknowledges it in the same access by clearing its pending bit. Read-only views show the raw pending bits and the pending bits qualified for each of the two outputs.

Both request outputs are computed combinationally from registered state. Read data is registered and appears in the cycle after the read strobe. The value returned reflects the state just before that clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, pending, enable, type, all priorities and the control word are zero, and the mask is 0x1F. Both request outputs are low, and each vector register reads 0xFFFFFFFF.
- R2: When a source input changes level, its pending bit takes the new level at the next clock edge. A level that stays the same does not set again a bit that was cleared by acknowledge or force.
- R3: `firq_o` is high exactly when some source is pending, enabled and has type bit 1. Type 1 means fast and type 0 means normal.
- R4: The candidates for the normal output are the sources that are pending, enabled and of type 0. With no candidate, `nirq_o` is low. With the mask at 0x1F, `nirq_o` is high when any candidate exists. Otherwise `nirq_o` is high only when some candidate's priority is strictly greater than the mask.
- R5: A write to index 2 sets the enable of the source numbered by bits [5:0] of the data. A write to index 3 clears that enable. Both of these indices read as zero. Index 4 accesses enable bits 63:32 and index 5 accesses enable bits 31:0.
- R6: Index 6 accesses type bits 63:32 and index 7 accesses type bits 31:0, for both read and write.
- R7: Register index k, for k from 8 to 15, accesses priority word 15-k. Word w holds the priorities of sources 8w to 8w+7, four bits each. Source 8w+j sits in bits [4j+3:4j].
- R8: A read of index 16 returns, among the normal candidates, the source with the highest priority, with ties going to the higher source number. The result is packed as source number in bits [21:16] and priority in bits [3:0]. The read clears that source's pending bit. With no candidate it returns 0xFFFFFFFF. The mask does not affect this read.
- R9: A read of index 17 returns the lowest-numbered source that is pending, enabled and of fast type, and clears its pending bit. With no such source it returns 0xFFFFFFFF.
- R10: Index 20 overwrites pending bits 63:32 and index 21 overwrites pending bits 31:0; both read as zero. Indices 18/19 read pending high/low. Indices 22/23 read the normal candidates high/low. Indices 24/25 read the fast candidates high/low.
- R11: The mask register at index 1 keeps data bits [4:0]. The control word at index 0 keeps data bits [7:0]. Writes to indices 16 to 19, 22 to 25 and any index above 25 change nothing. Reads of indices above 25 return zero.
- R12: A write takes effect at the clock edge where its strobe is sampled. The outputs show the new state after that edge and not before it. Read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 6 | Register word index for write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (vector reads acknowledge) |
| rd_idx_i | input | 6 | Register word index for read |
| rd_data_o | output | 32 | Registered read data |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check on every cycle that the fast output matches the fast-qualified pending bits and that the normal output is never raised without a normal candidate. They also check that a mask level between 16 and 30 blocks the normal output, that an empty fast-vector read returns all ones, and that mask writes and enable-by-number writes land. The bench scenarios cover the priority comparison swept over every mask value and every priority level. They also cover the reversed priority-word mapping, the tie-breaking and draining order of the vector reads, the held-level behaviour of the pending bits, and the registers whose writes are ignored.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
    parameter int SRC_N  = 64;   // number of sources
    parameter int DATA_W = 32;   // register word width
    parameter int PRIO_W = 4;    // per-source priority width
    parameter int MASK_W = 5;    // normal mask width
    parameter int IDX_W  = 6;    // register index width
    parameter int CTRL_W = 8;    // kept control bits

    localparam int SRC_IDX_W  = $clog2(SRC_N);
    localparam int PER_WORD   = DATA_W / PRIO_W;
    localparam int PRIO_WORDS = SRC_N / PER_WORD;
    localparam int PW_W       = $clog2(PRIO_WORDS);
    localparam int MASK_ALL   = (1 << MASK_W) - 1;
    localparam int VEC_SHIFT  = 16;

    typedef enum logic [IDX_W-1:0] {
        REG_CTRL     = 6'd0,
        REG_MASK     = 6'd1,
        REG_EN_NUM   = 6'd2,
        REG_DIS_NUM  = 6'd3,
        REG_EN_HI    = 6'd4,
        REG_EN_LO    = 6'd5,
        REG_TYPE_HI  = 6'd6,
        REG_TYPE_LO  = 6'd7,
        REG_NVEC     = 6'd16,
        REG_FVEC     = 6'd17,
        REG_SRC_HI   = 6'd18,
        REG_SRC_LO   = 6'd19,
        REG_FORCE_HI = 6'd20,
        REG_FORCE_LO = 6'd21,
        REG_NPEND_HI = 6'd22,
        REG_NPEND_LO = 6'd23,
        REG_FPEND_HI = 6'd24,
        REG_FPEND_LO = 6'd25
    } reg_idx_e;

    localparam logic [IDX_W-1:0] PRIO_BASE = 6'd8;
    localparam logic [IDX_W-1:0] PRIO_LAST = 6'd15;
endpackage

// File: rtl/irq_vc_prio_arb.sv
// Normal-source arbitration: best priority (ties to the higher number)
// and the mask-gated request.
module irq_vc_prio_arb
    import irq_vc_pkg::*;
(
    input  logic [SRC_N-1:0]        cand_i,
    input  logic [SRC_N*PRIO_W-1:0] prio_i,
    input  logic [MASK_W-1:0]       mask_i,
    output logic                    found_o,
    output logic [SRC_IDX_W-1:0]    idx_o,
    output logic [PRIO_W-1:0]       lvl_o,
    output logic                    req_o
);
    logic above;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        above   = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] >= lvl_o)) begin
                found_o = 1'b1;
                idx_o   = SRC_IDX_W'(i);
                lvl_o   = prio_i[i*PRIO_W +: PRIO_W];
            end
            if (cand_i[i] && (MASK_W'(prio_i[i*PRIO_W +: PRIO_W]) > mask_i))
                above = 1'b1;
        end
        req_o = (mask_i == MASK_W'(MASK_ALL)) ? (|cand_i) : above;
    end
endmodule

// File: rtl/irq_vc_fast_pick.sv
// Fast-source selection: lowest-numbered candidate wins.
module irq_vc_fast_pick
    import irq_vc_pkg::*;
(
    input  logic [SRC_N-1:0]     cand_i,
    output logic                 found_o,
    output logic [SRC_IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = SRC_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              nirq_o,
    output logic              firq_o
);
    // Architectural state
    logic [SRC_N-1:0]  pend_q, en_q, type_q, src_q;
    logic [SRC_N-1:0]  pend_d, en_d, type_d;
    logic [DATA_W-1:0] prio_q [PRIO_WORDS];
    logic [DATA_W-1:0] prio_d [PRIO_WORDS];
    logic [MASK_W-1:0] mask_q, mask_d;
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] rd_mux;

    // Flattened priorities for the arbiter
    logic [SRC_N*PRIO_W-1:0] prio_flat;
    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio
        assign prio_flat[w*DATA_W +: DATA_W] = prio_q[w];
    end

    // Qualified candidates
    logic [SRC_N-1:0] n_cand, f_cand;
    assign n_cand = pend_q & en_q & ~type_q;
    assign f_cand = pend_q & en_q & type_q;

    logic                 n_found, f_found;
    logic [SRC_IDX_W-1:0] n_idx, f_idx;
    logic [PRIO_W-1:0]    n_lvl;

    irq_vc_prio_arb u_arb (
        .cand_i  (n_cand),
        .prio_i  (prio_flat),
        .mask_i  (mask_q),
        .found_o (n_found),
        .idx_o   (n_idx),
        .lvl_o   (n_lvl),
        .req_o   (nirq_o)
    );

    irq_vc_fast_pick u_fast (
        .cand_i  (f_cand),
        .found_o (f_found),
        .idx_o   (f_idx)
    );

    assign firq_o = f_found;

    // Index decode helpers
    logic             wr_prio, rd_prio;
    logic [PW_W-1:0]  wr_word, rd_word;
    logic [SRC_IDX_W-1:0] wr_num;
    assign wr_prio = (wr_idx_i >= PRIO_BASE) && (wr_idx_i <= PRIO_LAST);
    assign rd_prio = (rd_idx_i >= PRIO_BASE) && (rd_idx_i <= PRIO_LAST);
    assign wr_word = PW_W'(PRIO_LAST - wr_idx_i);
    assign rd_word = PW_W'(PRIO_LAST - rd_idx_i);
    assign wr_num  = wr_data_i[SRC_IDX_W-1:0];

    // Next-state: input tracking, then writes, then acknowledges
    always_comb begin
        logic [SRC_N-1:0] chg;
        chg    = src_i ^ src_q;
        pend_d = (pend_q & ~chg) | (src_i & chg);
        en_d   = en_q;
        type_d = type_q;
        mask_d = mask_q;
        ctrl_d = ctrl_q;
        for (int w = 0; w < PRIO_WORDS; w++) prio_d[w] = prio_q[w];

        if (wr_en_i) begin
            case (wr_idx_i)
                REG_CTRL:     ctrl_d = wr_data_i[CTRL_W-1:0];
                REG_MASK:     mask_d = wr_data_i[MASK_W-1:0];
                REG_EN_NUM:   en_d[wr_num] = 1'b1;
                REG_DIS_NUM:  en_d[wr_num] = 1'b0;
                REG_EN_HI:    en_d[SRC_N-1 -: DATA_W] = wr_data_i;
                REG_EN_LO:    en_d[DATA_W-1:0] = wr_data_i;
                REG_TYPE_HI:  type_d[SRC_N-1 -: DATA_W] = wr_data_i;
                REG_TYPE_LO:  type_d[DATA_W-1:0] = wr_data_i;
                REG_FORCE_HI: pend_d[SRC_N-1 -: DATA_W] = wr_data_i;
                REG_FORCE_LO: pend_d[DATA_W-1:0] = wr_data_i;
                default: begin
                    if (wr_prio) prio_d[wr_word] = wr_data_i;
                end
            endcase
        end

        if (rd_en_i && rd_idx_i == REG_NVEC && n_found) pend_d[n_idx] = 1'b0;
        if (rd_en_i && rd_idx_i == REG_FVEC && f_found) pend_d[f_idx] = 1'b0;
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        case (rd_idx_i)
            REG_CTRL:     rd_mux = DATA_W'(ctrl_q);
            REG_MASK:     rd_mux = DATA_W'(mask_q);
            REG_EN_HI:    rd_mux = en_q[SRC_N-1 -: DATA_W];
            REG_EN_LO:    rd_mux = en_q[DATA_W-1:0];
            REG_TYPE_HI:  rd_mux = type_q[SRC_N-1 -: DATA_W];
            REG_TYPE_LO:  rd_mux = type_q[DATA_W-1:0];
            REG_NVEC:     rd_mux = n_found ? ((DATA_W'(n_idx) << VEC_SHIFT) | DATA_W'(n_lvl)) : '1;
            REG_FVEC:     rd_mux = f_found ? DATA_W'(f_idx) : '1;
            REG_SRC_HI:   rd_mux = pend_q[SRC_N-1 -: DATA_W];
            REG_SRC_LO:   rd_mux = pend_q[DATA_W-1:0];
            REG_NPEND_HI: rd_mux = n_cand[SRC_N-1 -: DATA_W];
            REG_NPEND_LO: rd_mux = n_cand[DATA_W-1:0];
            REG_FPEND_HI: rd_mux = f_cand[SRC_N-1 -: DATA_W];
            REG_FPEND_LO: rd_mux = f_cand[DATA_W-1:0];
            default: begin
                if (rd_prio) rd_mux = prio_q[rd_word];
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            en_q      <= '0;
            type_q    <= '0;
            src_q     <= '0;
            mask_q    <= MASK_W'(MASK_ALL);
            ctrl_q    <= '0;
            rd_data_o <= '0;
            for (int w = 0; w < PRIO_WORDS; w++) prio_q[w] <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            type_q <= type_d;
            src_q  <= src_i;
            mask_q <= mask_d;
            ctrl_q <= ctrl_d;
            for (int w = 0; w < PRIO_WORDS; w++) prio_q[w] <= prio_d[w];
            if (rd_en_i) rd_data_o <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_vc_chk.sv
module irq_vc_chk
    import irq_vc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [IDX_W-1:0]     wr_idx_i,
    input logic [SRC_IDX_W-1:0] wr_num_i,
    input logic                 rd_en_i,
    input logic [IDX_W-1:0]     rd_idx_i,
    input logic [DATA_W-1:0]    rd_data_o,
    input logic                 nirq_o,
    input logic                 firq_o,
    input logic [SRC_N-1:0]     pend_q,
    input logic [SRC_N-1:0]     en_q,
    input logic [SRC_N-1:0]     type_q,
    input logic [MASK_W-1:0]    mask_q
);
    // R3
    fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        firq_o == (|(pend_q & en_q & type_q)));

    // R4
    nirq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nirq_o |-> (|(pend_q & en_q & ~type_q)));

    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q >= MASK_W'(1 << PRIO_W) && mask_q != MASK_W'(MASK_ALL)) |-> !nirq_o);

    // R9
    fvec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_idx_i == REG_FVEC && !firq_o) |=> (rd_data_o == '1));

    // R9
    fvec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_idx_i == REG_FVEC && firq_o) |=> (rd_data_o < DATA_W'(SRC_N)));

    // R11
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == REG_MASK) |=> (mask_q == $past(wr_num_i[MASK_W-1:0])));

    // R5
    en_num_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == REG_EN_NUM) |=> en_q[$past(wr_num_i)]);

    // R5
    num_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (rd_idx_i == REG_EN_NUM || rd_idx_i == REG_DIS_NUM)) |=> (rd_data_o == '0));
endmodule

bind irq_vector_ctrl irq_vc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_num_i  (wr_data_i[irq_vc_pkg::SRC_IDX_W-1:0]),
    .rd_en_i   (rd_en_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .nirq_o    (nirq_o),
    .firq_o    (firq_o),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .type_q    (type_q),
    .mask_q    (mask_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        nirq, firq;

    int checks = 0;
    int errors = 0;

    // Bench model of software-visible state
    logic [63:0] m_pend = '0, m_en = '0, m_typ = '0;
    logic [3:0]  m_prio [64];
    logic [4:0]  m_mask = 5'h1F;
    logic [7:0]  m_ctrl = '0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .nirq_o    (nirq),
        .firq_o    (firq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_nvec();
        logic [63:0] c = m_pend & m_en & ~m_typ;
        for (int l = 15; l >= 0; l--)
            for (int i = 63; i >= 0; i--)
                if (c[i] && m_prio[i] == 4'(l)) return (32'(i) << 16) | 32'(l);
        return '1;
    endfunction

    function automatic logic [31:0] exp_fvec();
        logic [63:0] c = m_pend & m_en & m_typ;
        for (int i = 0; i < 64; i++) if (c[i]) return 32'(i);
        return '1;
    endfunction

    function automatic logic exp_nirq();
        logic [63:0] c = m_pend & m_en & ~m_typ;
        for (int i = 0; i < 64; i++)
            if (c[i] && (m_mask == 5'h1F || {1'b0, m_prio[i]} > m_mask)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        logic [31:0] r = '0;
        case (idx)
            0:  r = 32'(m_ctrl);
            1:  r = 32'(m_mask);
            4:  r = m_en[63:32];
            5:  r = m_en[31:0];
            6:  r = m_typ[63:32];
            7:  r = m_typ[31:0];
            16: r = exp_nvec();
            17: r = exp_fvec();
            18: r = m_pend[63:32];
            19: r = m_pend[31:0];
            22: r = (m_pend & m_en & ~m_typ) >> 32;
            23: r = 32'(m_pend & m_en & ~m_typ);
            24: r = (m_pend & m_en & m_typ) >> 32;
            25: r = 32'(m_pend & m_en & m_typ);
            default: begin
                if (idx >= 8 && idx <= 15)
                    for (int j = 0; j < 8; j++) r[j*4 +: 4] = m_prio[(15 - idx) * 8 + j];
            end
        endcase
        return r;
    endfunction

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic mwr(input int idx, input logic [31:0] d);
        case (idx)
            0:  m_ctrl = d[7:0];
            1:  m_mask = d[4:0];
            2:  m_en[d[5:0]] = 1'b1;
            3:  m_en[d[5:0]] = 1'b0;
            4:  m_en[63:32] = d;
            5:  m_en[31:0] = d;
            6:  m_typ[63:32] = d;
            7:  m_typ[31:0] = d;
            20: m_pend[63:32] = d;
            21: m_pend[31:0] = d;
            default: begin
                if (idx >= 8 && idx <= 15)
                    for (int j = 0; j < 8; j++) m_prio[(15 - idx) * 8 + j] = d[j*4 +: 4];
            end
        endcase
        wr(idx, d);
    endtask

    task automatic chk_out(input string req);
        check({req, " nirq"}, 32'(nirq), 32'(exp_nirq()));
        check({req, " firq"}, 32'(firq), 32'(|(m_pend & m_en & m_typ)));
    endtask

    task automatic rchk(input string req, input int idx);
        logic [31:0] e, a;
        e = exp_read(idx);
        rd(idx, a);
        check({req, " read"}, a, e);
        if (idx == 16 && e != '1) m_pend[e[21:16]] = 1'b0;
        if (idx == 17 && e != '1) m_pend[e[5:0]] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] e;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 nirq", 32'(nirq), 32'h0);
        check("R1 firq", 32'(firq), 32'h0);
        rchk("R1", 1);
        rchk("R1", 0);
        rchk("R1", 5);
        rchk("R1", 6);
        rchk("R1", 8);
        check("R1 nvec", exp_nvec(), 32'hFFFF_FFFF);
        rchk("R1", 16);
        rchk("R1", 17);
        rchk("R1", 19);

        // R5 enable by number, only low 6 data bits matter
        for (int n = 0; n < 64; n++) mwr(2, 32'hFFFF_FFC0 | 32'(n));
        check("R5 model", m_en[31:0], 32'hFFFF_FFFF);
        rchk("R5", 4);
        rchk("R5", 5);
        rchk("R5", 2);
        for (int n = 1; n < 64; n += 2) mwr(3, 32'(n));
        rchk("R5", 4);
        rchk("R5", 5);
        rchk("R5", 3);

        // R6 type halves
        mwr(6, 32'hF0F0_0000);
        mwr(7, 32'h0000_000F);
        rchk("R6", 6);
        rchk("R6", 7);

        // R7 priority words, reversed index
        for (int k = 8; k <= 15; k++) mwr(k, 32'h7654_3210 + 32'h1111_1111 * 32'(k - 8));
        for (int k = 8; k <= 15; k++) rchk("R7", k);
        check("R7 src0 prio", 32'(m_prio[0]), 32'h7);
        mwr(5, '1);
        mwr(4, '1);

        // R10 force and views, R3/R4 outputs
        mwr(21, 32'hA5A5_0F0F);
        mwr(20, 32'h8001_2400);
        for (int k = 18; k <= 25; k++) rchk("R10", k);
        chk_out("R3 R4 forced");

        // R11 mask keeps low 5 bits; R4 gating at mid level
        mwr(1, 32'hFFFF_FF08);
        rchk("R11 mask", 1);
        chk_out("R4 mask8");

        // R8 drain normal vector in priority order
        for (int s = 0; s < 70; s++) begin
            e = exp_nvec();
            rchk("R8", 16);
            chk_out("R8 after ack");
            if (e == '1) break;
        end
        // R9 drain fast vector lowest first
        for (int s = 0; s < 70; s++) begin
            e = exp_fvec();
            rchk("R9", 17);
            chk_out("R9 after ack");
            if (e == '1) break;
        end

        // R4 sweep: one normal source (5), every priority against every mask
        mwr(6, '0); mwr(7, '0);
        mwr(4, '0); mwr(5, 32'h20);
        mwr(20, '0); mwr(21, 32'h20);
        for (int p = 0; p < 16; p++) begin
            mwr(15, 32'(p) << 20);
            for (int m = 0; m < 32; m++) begin
                mwr(1, 32'(m));
                check("R4 sweep", 32'(nirq), 32'((m == 31) || (p > m)));
            end
        end

        // R11 ignored writes and unmapped reads
        mwr(4, '1); mwr(5, '1);
        mwr(21, 32'h0000_1234);
        mwr(7, 32'h0000_1200);
        foreach (e[i]) begin end
        for (int k = 16; k <= 19; k++) wr(k, '1);
        for (int k = 22; k <= 25; k++) wr(k, '1);
        wr(26, '1); wr(40, '1); wr(63, '1);
        for (int k = 18; k <= 25; k++) if (k != 20 && k != 21) rchk("R11 ignored", k);
        rchk("R11 ignored type", 7);
        rchk("R11 unmapped", 30);
        rchk("R11 unmapped", 63);
        mwr(0, 32'hFFFF_FFFF);
        rchk("R11 ctrl", 0);

        // R2 pending follows input changes only
        mwr(21, '0); mwr(20, '0);
        @(negedge clk);
        src[40] = 1'b1;
        m_pend[40] = 1'b1;
        rchk("R2 rise", 18);
        mwr(20, '0);
        rchk("R2 held after force", 18);
        @(negedge clk); src[40] = 1'b0;
        @(negedge clk); src[40] = 1'b1;
        m_pend[40] = 1'b1;
        rchk("R2 re-rise", 18);
        rchk("R2 R8 ack", 16);
        rchk("R2 held after ack", 18);
        src[40] = 1'b0;
        @(negedge clk);

        // R12 write takes effect only at the edge
        mwr(20, 32'h100);
        mwr(6, 32'h100);
        check("R12 before", 32'(firq), 32'h1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd3; wr_data = 32'd40;
        #1 check("R12 not yet", 32'(firq), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        m_en[40] = 1'b0;
        check("R12 after edge", 32'(firq), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule